// File: doc/BRIEF.md
# Conditional Branch Resolver

This block decides, for one conditional jump per cycle, whether the branch is taken and what the following program counter is. It receives two 32-bit operands, a 4-bit condition selector, a 5-bit signed displacement and the program counter of the branch itself. One clock later it presents a taken flag, the next program counter and a flag that marks an unassigned condition code.

Conditions come in two groups. The single-operand group tests operand A alone against zero (zero, negative, non-positive, positive, non-negative, non-zero); an always-taken code belongs to the same group. The two-operand group compares A with B (equal, signed less, signed less-or-equal, unsigned greater, unsigned greater-or-equal, not-equal). The target is relative to the branch: a displacement of +1 hops over exactly one following instruction, and an always-taken jump with displacement -1 lands on itself and spins.

Top module: `brx_resolver`

## Requirements
- R1: While rst_n is low and on the first cycle after it, res_valid, res_taken and res_bad_cond are 0 and res_next_pc is 0.
- R2: res_valid equals req_valid of the previous clock edge; all results belong to the request sampled on that edge (latency one cycle).
- R3: Single-operand codes compare A with zero as a signed 32-bit value: 1 A==0, 2 A<0, 3 A<=0, 4 A>0, 5 A>=0, 6 A!=0.
- R4: Two-operand signed and equality codes: 8 A==B, 9 A<B signed, 10 A<=B signed, 13 A!=B.
- R5: Two-operand unsigned codes: 11 A>B unsigned, 12 A>=B unsigned.
- R6: Code 0 is always taken whatever the operands.
- R7: A taken branch gives res_next_pc = pc + 1 + sign-extended displacement.
- R8: A branch not taken gives res_next_pc = pc + 1.
- R9: Displacement +1 on a taken branch gives pc + 2 (one instruction skipped); displacement -1 on code 0 gives pc itself.
- R10: Codes 7, 14 and 15 are never taken and raise res_bad_cond; every legal code leaves res_bad_cond low.
- R11: Program counter arithmetic wraps modulo 2^PC_W (0xFFFF + 1 gives 0; 0 + 1 - 16 gives 0xFFF1 for PC_W = 16).
- R12: A cycle with req_valid low changes neither res_taken, res_bad_cond nor res_next_pc, and drives res_valid low on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A branch request is present this cycle |
| req_a | input | 32 | First operand |
| req_b | input | 32 | Second operand |
| req_cond | input | 4 | Condition selector |
| req_disp | input | 5 | Signed displacement |
| req_pc | input | 16 | Program counter of the branch |
| res_valid | output | 1 | Result valid |
| res_taken | output | 1 | Branch taken |
| res_next_pc | output | 16 | Following program counter |
| res_bad_cond | output | 1 | Condition code is unassigned |

## Verification
On every cycle the assertions check the one-cycle valid pipeline, that results hold when no request arrives, that an unassigned code never yields a taken branch, that an untaken branch falls through to pc + 1, that code 0 is always taken and that a displacement of +1 lands two past the branch. The correctness of each comparison, in particular the split between signed and unsigned ordering at 0, -1, 0x7FFFFFFF and 0x80000000, and the wrap of the target at the ends of the address space, only show up in the bench, which runs every code against every pair of those boundary values and against random operands through a behavioural model.

// File: rtl/brx_pkg.sv
package brx_pkg;
    localparam int DATA_W = 32;
    localparam int COND_W = 4;

    typedef enum logic [COND_W-1:0] {
        CND_ALWAYS = 4'd0,
        CND_ZERO   = 4'd1,
        CND_NEG    = 4'd2,
        CND_NPOS   = 4'd3,
        CND_POS    = 4'd4,
        CND_NNEG   = 4'd5,
        CND_NZERO  = 4'd6,
        CND_RSV7   = 4'd7,
        CND_EQ     = 4'd8,
        CND_SLT    = 4'd9,
        CND_SLE    = 4'd10,
        CND_UGT    = 4'd11,
        CND_UGE    = 4'd12,
        CND_NE     = 4'd13,
        CND_RSV14  = 4'd14,
        CND_RSV15  = 4'd15
    } cond_e;

    typedef struct packed {
        logic a_zero;
        logic a_neg;
        logic ab_eq;
        logic ab_slt;
        logic ab_ult;
    } flags_t;
endpackage

// File: rtl/brx_flags.sv
module brx_flags
    import brx_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output flags_t       flg
);
    localparam int MSB = W - 1;

    logic sign_diff;
    logic mag_lt;

    always_comb begin
        sign_diff     = a[MSB] ^ b[MSB];
        mag_lt        = a < b;
        flg.a_zero    = (a == '0);
        flg.a_neg     = a[MSB];
        flg.ab_eq     = (a == b);
        flg.ab_ult    = mag_lt;
        // a negative, b non-negative -> a smaller; same sign -> magnitude order
        flg.ab_slt    = sign_diff ? a[MSB] : mag_lt;
    end
endmodule

// File: rtl/brx_decide.sv
module brx_decide
    import brx_pkg::*;
(
    input  logic [COND_W-1:0] cond,
    input  flags_t            flg,
    output logic              take,
    output logic              bad
);
    always_comb begin
        take = 1'b0;
        bad  = 1'b0;
        unique case (cond_e'(cond))
            CND_ALWAYS: take = 1'b1;
            CND_ZERO:   take = flg.a_zero;
            CND_NEG:    take = flg.a_neg;
            CND_NPOS:   take = flg.a_neg | flg.a_zero;
            CND_POS:    take = ~flg.a_neg & ~flg.a_zero;
            CND_NNEG:   take = ~flg.a_neg;
            CND_NZERO:  take = ~flg.a_zero;
            CND_EQ:     take = flg.ab_eq;
            CND_SLT:    take = flg.ab_slt;
            CND_SLE:    take = flg.ab_slt | flg.ab_eq;
            CND_UGT:    take = ~flg.ab_ult & ~flg.ab_eq;
            CND_UGE:    take = ~flg.ab_ult;
            CND_NE:     take = ~flg.ab_eq;
            default:    bad  = 1'b1;
        endcase
    end
endmodule

// File: rtl/brx_target.sv
module brx_target #(
    parameter int PC_W   = 16,
    parameter int DISP_W = 5
) (
    input  logic [PC_W-1:0]   pc,
    input  logic [DISP_W-1:0] disp,
    input  logic              take,
    output logic [PC_W-1:0]   next_pc
);
    localparam int EXT_W = PC_W - DISP_W;

    logic [PC_W-1:0] disp_ext;
    logic [PC_W-1:0] seq_pc;

    generate
        if (EXT_W > 0) begin : g_ext
            assign disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};
        end else begin : g_trunc
            assign disp_ext = disp[PC_W-1:0];
        end
    endgenerate

    always_comb begin
        seq_pc  = pc + PC_W'(1);
        next_pc = take ? (seq_pc + disp_ext) : seq_pc;
    end
endmodule

// File: rtl/brx_resolver.sv
module brx_resolver
    import brx_pkg::*;
#(
    parameter int PC_W   = 16,
    parameter int DISP_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [31:0]       req_a,
    input  logic [31:0]       req_b,
    input  logic [3:0]        req_cond,
    input  logic [DISP_W-1:0] req_disp,
    input  logic [PC_W-1:0]   req_pc,
    output logic              res_valid,
    output logic              res_taken,
    output logic [PC_W-1:0]   res_next_pc,
    output logic              res_bad_cond
);
    typedef struct packed {
        logic            valid;
        logic            taken;
        logic            bad;
        logic [PC_W-1:0] npc;
    } res_t;

    flags_t          flg;
    logic            take_w;
    logic            bad_w;
    logic [PC_W-1:0] npc_w;
    res_t            res_d, res_q;

    brx_flags #(.W(DATA_W)) u_flags (
        .a   (req_a),
        .b   (req_b),
        .flg (flg)
    );

    brx_decide u_decide (
        .cond (req_cond),
        .flg  (flg),
        .take (take_w),
        .bad  (bad_w)
    );

    brx_target #(.PC_W(PC_W), .DISP_W(DISP_W)) u_target (
        .pc      (req_pc),
        .disp    (req_disp),
        .take    (take_w),
        .next_pc (npc_w)
    );

    always_comb begin
        res_d       = res_q;
        res_d.valid = req_valid;
        if (req_valid) begin
            res_d.taken = take_w;
            res_d.bad   = bad_w;
            res_d.npc   = npc_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign res_valid    = res_q.valid;
    assign res_taken    = res_q.taken;
    assign res_bad_cond = res_q.bad;
    assign res_next_pc  = res_q.npc;

    p_valid_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> res_valid);
    p_valid_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !res_valid);
    p_hold_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(res_taken) && $stable(res_next_pc) && $stable(res_bad_cond)));
    p_bad_not_taken_r10: assert property (@(posedge clk) disable iff (!rst_n)
        res_bad_cond |-> !res_taken);
    p_fallthrough_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (res_taken || res_next_pc == PC_W'($past(req_pc) + PC_W'(1))));
    p_always_taken_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_cond == 4'd0) |=> res_taken);
    p_skip_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_disp == DISP_W'(1)) |=>
            (!res_taken || res_next_pc == PC_W'($past(req_pc) + PC_W'(2))));
endmodule

// File: tb/test_brx_resolver.sv
module test_brx_resolver;
    localparam int PCW = 16;
    localparam int DW  = 5;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic [31:0]     req_a = '0;
    logic [31:0]     req_b = '0;
    logic [3:0]      req_cond = '0;
    logic [DW-1:0]   req_disp = '0;
    logic [PCW-1:0]  req_pc = '0;
    logic            res_valid, res_taken, res_bad_cond;
    logic [PCW-1:0]  res_next_pc;

    int n_tests = 0;
    int n_fail  = 0;

    // model state
    bit       e_valid = 0, e_taken = 0, e_bad = 0;
    int       e_npc = 0;
    string    tag_take = "R1", tag_pc = "R1";

    always #2 clk = ~clk;

    brx_resolver #(.PC_W(PCW), .DISP_W(DW)) i_brx_resolver (
        .clk, .rst_n, .req_valid, .req_a, .req_b, .req_cond, .req_disp, .req_pc,
        .res_valid, .res_taken, .res_next_pc, .res_bad_cond
    );

    task automatic chk(input string tag, input string what, input longint act, input longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic bit ref_take(input int c, input logic [31:0] a, input logic [31:0] b);
        longint sa, sb, ua, ub;
        sa = longint'($signed(a)); sb = longint'($signed(b));
        ua = longint'(a);          ub = longint'(b);
        case (c)
            0:  return 1;
            1:  return sa == 0;
            2:  return sa < 0;
            3:  return sa <= 0;
            4:  return sa > 0;
            5:  return sa >= 0;
            6:  return sa != 0;
            8:  return ua == ub;
            9:  return sa < sb;
            10: return sa <= sb;
            11: return ua > ub;
            12: return ua >= ub;
            13: return ua != ub;
            default: return 0;
        endcase
    endfunction

    function automatic string cond_tag(input int c);
        if (c == 0) return "R6";
        if (c >= 1 && c <= 6) return "R3";
        if (c == 11 || c == 12) return "R5";
        if (c == 7 || c >= 14) return "R10";
        return "R4";
    endfunction

    // drive after a negedge: check the previous expectation first, then apply new stimulus
    task automatic step(input bit v, input int c, input logic [31:0] a, input logic [31:0] b,
                        input int d, input int pc);
        @(negedge clk);
        chk("R2", "valid", res_valid, e_valid);
        chk(tag_take, "taken", res_taken, e_taken);
        chk("R10", "bad_cond", res_bad_cond, e_bad);
        chk(tag_pc, "next_pc", res_next_pc, e_npc);
        req_valid = v; req_cond = 4'(c); req_a = a; req_b = b;
        req_disp = DW'(d); req_pc = PCW'(pc);
        e_valid = v;
        if (v) begin
            int sd;
            sd = d;
            if (sd >= 16) sd -= 32;
            e_taken = ref_take(c, a, b);
            e_bad   = (c == 7 || c >= 14);
            e_npc   = (pc + 1 + (e_taken ? sd : 0)) & ((1 << PCW) - 1);
            tag_take = cond_tag(c);
            if (pc + 1 + (e_taken ? sd : 0) != e_npc) tag_pc = "R11";
            else if (e_taken && (sd == 1 || sd == -1)) tag_pc = "R9";
            else if (e_taken) tag_pc = "R7";
            else tag_pc = "R8";
        end else begin
            tag_take = "R12";
            tag_pc   = "R12";
        end
    endtask

    initial begin : watchdog
        #400000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : stim
        logic [31:0] bnd [4];
        bnd[0] = 32'h0; bnd[1] = 32'hFFFF_FFFF; bnd[2] = 32'h7FFF_FFFF; bnd[3] = 32'h8000_0000;
        // R1: reset state, during and right after reset
        repeat (3) @(negedge clk);
        chk("R1", "valid", res_valid, 0);
        chk("R1", "taken", res_taken, 0);
        chk("R1", "bad", res_bad_cond, 0);
        chk("R1", "npc", res_next_pc, 0);
        rst_n = 1'b1;
        // boundary operand sweep, every code
        for (int c = 0; c < 16; c++)
            for (int i = 0; i < 4; i++)
                for (int j = 0; j < 4; j++)
                    step(1, c, bnd[i], bnd[j], (c + i + j) % 32, 16'h0100 + c * 16 + i * 4 + j);
        // R9: skip one and self-loop
        step(1, 0, 0, 0, 1, 16'h0200);
        step(1, 0, 0, 0, 31, 16'h0300);
        step(1, 1, 0, 5, 1, 16'h0400);
        // R11: wrap at both ends
        step(1, 0, 0, 0, 0, 16'hFFFF);
        step(1, 6, 0, 0, 0, 16'hFFFF);
        step(1, 0, 0, 0, 16, 16'h0000);
        step(1, 0, 0, 0, 15, 16'hFFF5);
        // R12: idle cycles with junk inputs hold previous result
        step(1, 9, 32'h8000_0000, 32'h1, 7, 16'h1234);
        step(0, 0, 32'h5, 32'h6, 3, 16'h9999);
        step(0, 14, 32'h0, 32'h0, 2, 16'h7777);
        step(1, 15, 32'h1, 32'h1, 4, 16'h0042);
        step(0, 0, 0, 0, 0, 0);
        // random traffic
        for (int k = 0; k < 3000; k++)
            step(($urandom % 5) != 0, $urandom % 16, $urandom, ($urandom % 4 == 0) ? req_a : $urandom,
                 $urandom % 32, $urandom % 65536);
        step(0, 0, 0, 0, 0, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule